// File: doc/BRIEF.md
# Floating-Point Overflow Default Result Selector

When a rounded floating-point result is too large for its destination format, something still has to be stored. This block picks that value. The choice depends on the active rounding direction and on the sign of the intermediate result. In some cases it is an infinity. In the others it is the largest finite number the destination format can hold, carrying the intermediate sign.

The value is always delivered as an 80-bit extended-precision pattern:

- bit 79 is the sign;
- bits 78:64 are the biased 15-bit exponent, with a bias of 16383;
- bits 63:0 are the mantissa, with an explicit integer bit at bit 63.

For single and double destinations, the pattern is the extended-precision form of the largest value that the narrower format can represent. This lets a later converter narrow it without further loss.

If the overflow trap is enabled, the stored pattern does not change, and the block also raises an exception request. One request strobe goes in and, one clock later, one registered result with its own valid strobe comes out. Between strobes the outputs keep their last value.

Top module: `ovf_default_result`

## Requirements
- R1: With rounding code 00 (to nearest), an overflow yields infinity with the intermediate sign.
- R2: With rounding code 01 (toward zero), an overflow yields the largest finite value of the destination format, with the intermediate sign.
- R3: With rounding code 10 (toward minus infinity), a positive overflow yields the largest positive finite value and a negative overflow yields minus infinity.
- R4: With rounding code 11 (toward plus infinity), a positive overflow yields plus infinity and a negative overflow yields the largest negative finite value.
- R5: On every overflow, result bit 79 equals the intermediate sign input.
- R6: Infinity is exponent field 0x7FFF with an all-zero mantissa, whatever the destination format.
- R7: For format code 00 (extended), the largest finite value is exponent 0x7FFE with mantissa 0xFFFFFFFFFFFFFFFF. Format code 11 is reserved and is treated as extended.
- R8: For format code 01 (single), the largest finite value is exponent 0x407E with mantissa 0xFFFFFF0000000000. For format code 10 (double), it is exponent 0x43FE with mantissa 0xFFFFFFFFFFFFF800.
- R9: When an overflow occurs with the trap enabled, exc_req is high together with out_valid and the result is the same as with the trap disabled. Otherwise exc_req is low whenever out_valid is high.
- R10: A request without overflow produces a result of all zeros and no exception request.
- R11: out_valid is high exactly one clock after a cycle with in_valid high. Without in_valid, result and exc_req hold their values. Reset clears out_valid, result and exc_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| ovf | input | 1 | The rounded result overflowed the destination |
| sign | input | 1 | Sign of the intermediate result |
| rmode | input | 2 | Rounding code (00 nearest, 01 zero, 10 minus, 11 plus) |
| fmt | input | 2 | Destination format (00 ext, 01 single, 10 double, 11 ext) |
| trap_en | input | 1 | Overflow trap enable |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 80 | Default result: sign, 15-bit exponent, 64-bit mantissa |
| exc_req | output | 1 | Exception request accompanying out_valid |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent, a 64-bit mantissa, 24 and 53 bits of precision, and maximum exponents of 127 and 1023. With these values, all three maximum-finite patterns and the shared infinity pattern can be compared against constants the bench writes out literally. A directed sweep visits every combination of rounding code, sign and format code, including the reserved format. Seeded random requests then mix overflow, trap enable and idle gaps, which exercises the hold and latency behaviour.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_ZERO  = 2'b01,
    RM_MINUS = 2'b10,
    RM_PLUS  = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    FMT_EXT = 2'b00,
    FMT_SGL = 2'b01,
    FMT_DBL = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

endpackage

// File: rtl/ovf_mode_decode.sv
// Decides, from rounding direction and sign, whether an overflow
// saturates to infinity or clamps to the largest finite value.
module ovf_mode_decode
  import ovf_pkg::*;
(
  input  rmode_e rmode,
  input  logic   sign,
  output logic   pick_inf
);

  always_comb begin
    unique case (rmode)
      RM_NEAR:  pick_inf = 1'b1;
      RM_ZERO:  pick_inf = 1'b0;
      RM_MINUS: pick_inf = sign;   // only the negative side goes to -inf
      RM_PLUS:  pick_inf = ~sign;  // only the positive side goes to +inf
      default:  pick_inf = 1'b1;
    endcase
  end

endmodule

// File: rtl/ovf_pattern_table.sv
// Largest finite value of each destination format, written in
// extended-precision layout. Entries are computed from the format
// parameters; reserved format code falls back to extended.
module ovf_pattern_table
  import ovf_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MAN_W    = 64,
  parameter int SGL_PREC = 24,
  parameter int SGL_EMAX = 127,
  parameter int DBL_PREC = 53,
  parameter int DBL_EMAX = 1023
) (
  input  fmt_e             fmt,
  output logic [EXP_W-1:0] max_exp,
  output logic [MAN_W-1:0] max_man
);

  localparam int EXT_BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int NFMT     = 3;

  function automatic logic [MAN_W-1:0] top_ones(input int prec);
    logic [MAN_W-1:0] m;
    m = '1;
    m = m << (MAN_W - prec);
    return m;
  endfunction

  function automatic logic [EXP_W-1:0] biased_emax(input int emax);
    return EXP_W'(EXT_BIAS + emax);
  endfunction

  logic [EXP_W-1:0] exp_tab [NFMT];
  logic [MAN_W-1:0] man_tab [NFMT];

  for (genvar i = 0; i < NFMT; i++) begin : g_fmt
    localparam int PREC = (i == 0) ? MAN_W : (i == 1) ? SGL_PREC : DBL_PREC;
    localparam int EMAX = (i == 0) ? EXT_BIAS : (i == 1) ? SGL_EMAX : DBL_EMAX;
    assign exp_tab[i] = biased_emax(EMAX);
    assign man_tab[i] = top_ones(PREC);
  end

  logic [1:0] sel;
  always_comb begin
    unique case (fmt)
      FMT_SGL: sel = 2'd1;
      FMT_DBL: sel = 2'd2;
      default: sel = 2'd0;
    endcase
  end

  assign max_exp = exp_tab[sel];
  assign max_man = man_tab[sel];

endmodule

// File: rtl/ovf_default_result.sv
module ovf_default_result
  import ovf_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MAN_W    = 64,
  parameter int SGL_PREC = 24,
  parameter int SGL_EMAX = 127,
  parameter int DBL_PREC = 53,
  parameter int DBL_EMAX = 1023
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   ovf,
  input  logic                   sign,
  input  logic [1:0]             rmode,
  input  logic [1:0]             fmt,
  input  logic                   trap_en,
  output logic                   out_valid,
  output logic [EXP_W+MAN_W:0]   result,
  output logic                   exc_req
);

  localparam int RES_W = EXP_W + MAN_W + 1;
  localparam logic [EXP_W-1:0] INF_EXP = '1;

  rmode_e rm_e;
  fmt_e   fmt_e_s;
  assign rm_e    = rmode_e'(rmode);
  assign fmt_e_s = fmt_e'(fmt);

  // Named internal events for the assertions
  logic             pick_inf;
  logic [EXP_W-1:0] max_exp;
  logic [MAN_W-1:0] max_man;
  logic             trap_hit;
  logic [RES_W-1:0] nxt_result;

  ovf_mode_decode u_decode (
    .rmode    (rm_e),
    .sign     (sign),
    .pick_inf (pick_inf)
  );

  ovf_pattern_table #(
    .EXP_W    (EXP_W),
    .MAN_W    (MAN_W),
    .SGL_PREC (SGL_PREC),
    .SGL_EMAX (SGL_EMAX),
    .DBL_PREC (DBL_PREC),
    .DBL_EMAX (DBL_EMAX)
  ) u_table (
    .fmt     (fmt_e_s),
    .max_exp (max_exp),
    .max_man (max_man)
  );

  function automatic logic [RES_W-1:0] build_result(
    input logic             o,
    input logic             s,
    input logic             inf,
    input logic [EXP_W-1:0] mexp,
    input logic [MAN_W-1:0] mman
  );
    if (!o) return '0;
    if (inf) return {s, INF_EXP, {MAN_W{1'b0}}};
    return {s, mexp, mman};
  endfunction

  assign nxt_result = build_result(ovf, sign, pick_inf, max_exp, max_man);
  assign trap_hit   = ovf & trap_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      exc_req   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_result;
        exc_req <= trap_hit;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(exc_req)));
  assert_near_inf_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf && rmode == 2'b00) |=>
      (result[RES_W-2 -: EXP_W] == INF_EXP && result[MAN_W-1:0] == '0));
  assert_zero_finite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf && rmode == 2'b01) |=> (result[RES_W-2 -: EXP_W] != INF_EXP));
  assert_minus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf && rmode == 2'b10) |=>
      ((result[RES_W-2 -: EXP_W] == INF_EXP) == result[RES_W-1]));
  assert_plus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf && rmode == 2'b11) |=>
      ((result[RES_W-2 -: EXP_W] == INF_EXP) == !result[RES_W-1]));
  assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf) |=> (result[RES_W-1] == $past(sign)));
  assert_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (exc_req == $past(ovf && trap_en)));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovf) |=> (result == '0 && !exc_req));
  assert_finite_mantissa_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovf && !pick_inf) |=> (result[MAN_W-1] && result[RES_W-2 -: EXP_W] != INF_EXP));

endmodule

// File: tb/ovf_default_result_tb.sv
module ovf_default_result_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        ovf = 1'b0;
  logic        sign = 1'b0;
  logic [1:0]  rmode = 2'b00;
  logic [1:0]  fmt = 2'b00;
  logic        trap_en = 1'b0;
  logic        out_valid;
  logic [79:0] result;
  logic        exc_req;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_default_result dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ovf(ovf), .sign(sign),
    .rmode(rmode), .fmt(fmt), .trap_en(trap_en),
    .out_valid(out_valid), .result(result), .exc_req(exc_req)
  );

  // Literal patterns taken from the requirements (R6, R7, R8)
  function automatic logic [79:0] largest(input logic s, input logic [1:0] f);
    case (f)
      2'b01:   return {s, 15'h407E, 64'hFFFF_FF00_0000_0000};
      2'b10:   return {s, 15'h43FE, 64'hFFFF_FFFF_FFFF_F800};
      default: return {s, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF};
    endcase
  endfunction

  function automatic logic [79:0] expect_res(input logic o, input logic s,
                                             input logic [1:0] rm, input logic [1:0] f);
    logic to_inf;
    if (!o) return 80'h0;
    // R1..R4: saturate to infinity when rounding points away from zero
    to_inf = (rm == 2'b00) || (rm == 2'b10 && s) || (rm == 2'b11 && !s);
    if (to_inf) return {s, 15'h7FFF, 64'h0};
    return largest(s, f);
  endfunction

  task automatic check(input string tag, input logic [79:0] got, input logic [79:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic string req_tag(input logic o, input logic [1:0] rm);
    if (!o) return "R10";
    case (rm)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic send(input logic o, input logic s, input logic [1:0] rm,
                      input logic [1:0] f, input logic t);
    logic [79:0] exp;
    @(negedge clk);
    in_valid = 1'b1; ovf = o; sign = s; rmode = rm; fmt = f; trap_en = t;
    @(negedge clk);
    in_valid = 1'b0;
    exp = expect_res(o, s, rm, f);
    check("R11 valid", {79'h0, out_valid}, 80'h1);
    check(req_tag(o, rm), result, exp);
    if (o) check("R5 sign", {79'h0, result[79]}, {79'h0, s});
    check("R9 exc_req", {79'h0, exc_req}, {79'h0, (o & t)});
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [79:0] held;
    logic        held_exc;
    void'($urandom(32'd7731));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset valid", {79'h0, out_valid}, 80'h0);
    check("R11 reset result", result, 80'h0);
    check("R11 reset exc", {79'h0, exc_req}, 80'h0);
    rst_n = 1'b1;

    // Directed sweep: every mode, sign and format code (R1-related sweep, R7, R8)
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 4; f++)
          send(1'b1, s[0], m[1:0], f[1:0], 1'b0);

    // R6: infinity identical for every format
    for (int f = 0; f < 3; f++) begin
      send(1'b1, 1'b1, 2'b00, f[1:0], 1'b0);
      check("R6 inf", result, {1'b1, 15'h7FFF, 64'h0});
    end
    // R7, R8 explicit
    send(1'b1, 1'b0, 2'b01, 2'b00, 1'b0);
    check("R7 ext max", result, {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF});
    send(1'b1, 1'b0, 2'b01, 2'b11, 1'b0);
    check("R7 reserved fmt", result, {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF});
    send(1'b1, 1'b1, 2'b01, 2'b01, 1'b0);
    check("R8 single max", result, {1'b1, 15'h407E, 64'hFFFF_FF00_0000_0000});
    send(1'b1, 1'b1, 2'b01, 2'b10, 1'b0);
    check("R8 double max", result, {1'b1, 15'h43FE, 64'hFFFF_FFFF_FFFF_F800});

    // R9: trap enabled leaves result unchanged
    send(1'b1, 1'b0, 2'b11, 2'b10, 1'b1);
    check("R9 trap result", result, {1'b0, 15'h7FFF, 64'h0});
    send(1'b0, 1'b1, 2'b11, 2'b10, 1'b1);
    check("R10 no ovf trap", {79'h0, exc_req}, 80'h0);

    // R11: hold while idle
    send(1'b1, 1'b1, 2'b11, 2'b01, 1'b1);
    held = result; held_exc = exc_req;
    repeat (3) @(negedge clk);
    check("R11 idle valid", {79'h0, out_valid}, 80'h0);
    check("R11 hold result", result, held);
    check("R11 hold exc", {79'h0, exc_req}, {79'h0, held_exc});

    // Random phase
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      send(r[0] | r[1], r[2], r[4:3], r[6:5], r[7]);
      if (r[9:8] == 2'b00) begin
        held = result;
        @(negedge clk);
        check("R11 random hold", result, held);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule